// File: doc/BRIEF.md
# Two-Master Banked SRAM Arbiter

This block puts a processor port and a peripheral port on one on-chip SRAM of 64 KB. The SRAM is split into two single-ported halves of 32 KB, the lower and upper bank. Each half has its own arbiter, so the two masters run side by side whenever they address different halves.

When both masters want the same half in the same cycle, a per-bank configuration bit names the winner. The other master sees its ready signal held low and keeps its request presented until it is served. No access is dropped or refused. Every access occupies its bank for one cycle, and read data comes back one cycle after the grant.

Top module: `banked_sram_arb`

## Requirements
- R1: Address bit 15 of the 16-bit byte address selects the bank: 0 is the lower bank (0x0000 to 0x7FFF) and 1 is the upper bank (0x8000 to 0xFFFF). Bits 14 down to 4 pick a 128-bit word, and bits 3 to 0 are ignored.
- R2: `bank_prio[0]` rules the lower bank and `bank_prio[1]` rules the upper bank. A 0 lets the processor port win a same-bank conflict, and a 1 lets the peripheral port win. Each bit affects only its own bank.
- R3: During a conflict the losing port's ready stays low for as long as the winner keeps requesting. Once the winner is idle, the held request is granted and takes full effect: its write lands after the winner's write, or its read returns the stored word. Two ports are never granted the same bank in one cycle.
- R4: Requests from the two ports to different banks are both granted in the same cycle.
- R5: An uncontested request gets ready in the same cycle it is presented.
- R6: After a granted read, the port's `rvalid` is high for exactly the next cycle and `rdata` holds the word read. A granted write or a stalled request produces no `rvalid`.
- R7: Arbitration does not depend on the word offset. Two requests to different words of one bank conflict in exactly the way two requests to the same word do.
- R8: While `rst_n` is low, and in the first cycle after reset, both `rvalid` outputs are low.
- R9: A word read back returns the data most recently written to it by either port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bank_prio | input | 2 | Conflict winner for each bank (0 = processor port, 1 = peripheral port) |
| cpu_req | input | 1 | Processor port request |
| cpu_we | input | 1 | Processor port write enable |
| cpu_addr | input | 16 | Processor port byte address |
| cpu_wdata | input | 128 | Processor port write data |
| cpu_ready | output | 1 | Processor port request is granted this cycle |
| cpu_rvalid | output | 1 | Processor port read data is valid |
| cpu_rdata | output | 128 | Processor port read data |
| dev_req | input | 1 | Peripheral port request |
| dev_we | input | 1 | Peripheral port write enable |
| dev_addr | input | 16 | Peripheral port byte address |
| dev_wdata | input | 128 | Peripheral port write data |
| dev_ready | output | 1 | Peripheral port request is granted this cycle |
| dev_rvalid | output | 1 | Peripheral port read data is valid |
| dev_rdata | output | 128 | Peripheral port read data |

## Verification
The hardest case to reach is a loser that has been stalled for several cycles and is then granted. Its write must land after the winner's write, and its read must return the stored word without a spurious `rvalid` during the stall. The stimulus sets up same-bank collisions under every priority setting and keeps the winner requesting for extra cycles. It then releases the winner and checks the memory contents by reading them back. Further collisions between different word offsets of one bank, and parallel traffic to opposite banks, show that the decision depends only on the bank bit and its priority bit.

// File: rtl/banked_sram_arb.sv
module banked_sram_arb #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bank_prio,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic              cpu_rvalid,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              dev_req,
  input  logic              dev_we,
  input  logic [ADDR_W-1:0] dev_addr,
  input  logic [DATA_W-1:0] dev_wdata,
  output logic              dev_ready,
  output logic              dev_rvalid,
  output logic [DATA_W-1:0] dev_rdata
);

  localparam int BYTE_LSB = $clog2(DATA_W / 8);
  localparam int BSEL     = ADDR_W - 1;
  localparam int IDX_W    = BSEL - BYTE_LSB;
  localparam int DEPTH    = 1 << IDX_W;

  logic [1:0]        cpu_hit, dev_hit, cpu_gnt, dev_gnt;
  logic [DATA_W-1:0] bank_rd [2];
  logic              cpu_bank_q, dev_bank_q;
  logic              unused_lsb;

  assign unused_lsb = ^{cpu_addr[BYTE_LSB-1:0], dev_addr[BYTE_LSB-1:0]};

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rd_q;
    logic              take_dev, wr;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] wd;

    assign cpu_hit[b] = cpu_req && (cpu_addr[BSEL] == 1'(b));
    assign dev_hit[b] = dev_req && (dev_addr[BSEL] == 1'(b));
    assign cpu_gnt[b] = cpu_hit[b] && (!dev_hit[b] || !bank_prio[b]);
    assign dev_gnt[b] = dev_hit[b] && (!cpu_hit[b] ||  bank_prio[b]);

    assign take_dev = dev_gnt[b];
    assign idx = take_dev ? dev_addr[BSEL-1:BYTE_LSB] : cpu_addr[BSEL-1:BYTE_LSB];
    assign wr  = take_dev ? dev_we    : cpu_we;
    assign wd  = take_dev ? dev_wdata : cpu_wdata;

    always_ff @(posedge clk) begin
      if (cpu_gnt[b] || dev_gnt[b]) begin
        if (wr) mem[idx] <= wd;
        else    rd_q     <= mem[idx];
      end
    end

    assign bank_rd[b] = rd_q;
  end

  assign cpu_ready = |cpu_gnt;
  assign dev_ready = |dev_gnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpu_rvalid <= 1'b0;
      dev_rvalid <= 1'b0;
      cpu_bank_q <= 1'b0;
      dev_bank_q <= 1'b0;
    end else begin
      cpu_rvalid <= cpu_ready && !cpu_we;
      dev_rvalid <= dev_ready && !dev_we;
      if (cpu_ready) cpu_bank_q <= cpu_addr[BSEL];
      if (dev_ready) dev_bank_q <= dev_addr[BSEL];
    end
  end

  assign cpu_rdata = bank_rd[cpu_bank_q];
  assign dev_rdata = bank_rd[dev_bank_q];

  logic same_bank;
  assign same_bank = cpu_req && dev_req && (cpu_addr[BSEL] == dev_addr[BSEL]);

  a_r3_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready && dev_ready |-> cpu_addr[BSEL] != dev_addr[BSEL]);

  a_r4_parallel: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req && dev_req && (cpu_addr[BSEL] != dev_addr[BSEL]) |-> cpu_ready && dev_ready);

  a_r2_cpu_wins: assert property (@(posedge clk) disable iff (!rst_n)
    same_bank && !bank_prio[cpu_addr[BSEL]] |-> cpu_ready && !dev_ready);

  a_r2_dev_wins: assert property (@(posedge clk) disable iff (!rst_n)
    same_bank && bank_prio[cpu_addr[BSEL]] |-> dev_ready && !cpu_ready);

  a_r5_uncontested: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !same_bank |-> cpu_ready) and (dev_req && !same_bank |-> dev_ready));

  a_r6_rvalid_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rvalid |-> $past(cpu_ready && !cpu_we)) and (dev_rvalid |-> $past(dev_ready && !dev_we)));

endmodule

// File: tb/banked_sram_arb_tb.sv
module banked_sram_arb_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] bank_prio = 2'b00;
  logic cpu_req = 0, cpu_we = 0, dev_req = 0, dev_we = 0;
  logic [15:0] cpu_addr = '0, dev_addr = '0;
  logic [127:0] cpu_wdata = '0, dev_wdata = '0;
  logic cpu_ready, cpu_rvalid, dev_ready, dev_rvalid;
  logic [127:0] cpu_rdata, dev_rdata;

  int vectors = 0, misses = 0;
  bit done = 0;
  logic s_crdy, s_drdy, s_crv, s_drv;
  logic [127:0] s_crd, s_drd;

  always #5 clk = ~clk;

  banked_sram_arb dut_i (
    .clk(clk), .rst_n(rst_n), .bank_prio(bank_prio),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
    .dev_req(dev_req), .dev_we(dev_we), .dev_addr(dev_addr), .dev_wdata(dev_wdata),
    .dev_ready(dev_ready), .dev_rvalid(dev_rvalid), .dev_rdata(dev_rdata)
  );

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Drive one cycle just after a falling edge; capture ready before the rising
  // edge and registered read results at the following falling edge.
  task automatic step(input logic cr, input logic cw, input logic [15:0] ca, input logic [127:0] cd,
                      input logic dr, input logic dw, input logic [15:0] da, input logic [127:0] dd);
    cpu_req = cr; cpu_we = cw; cpu_addr = ca; cpu_wdata = cd;
    dev_req = dr; dev_we = dw; dev_addr = da; dev_wdata = dd;
    #1;
    s_crdy = cpu_ready; s_drdy = dev_ready;
    @(negedge clk);
    s_crv = cpu_rvalid; s_drv = dev_rvalid; s_crd = cpu_rdata; s_drd = dev_rdata;
  endtask

  task automatic idle();
    step(0, 0, 16'h0, '0, 0, 0, 16'h0, '0);
  endtask

  task automatic t_reset();
    chk("R8 cpu_rvalid in reset", 128'(cpu_rvalid), 0);
    chk("R8 dev_rvalid in reset", 128'(dev_rvalid), 0);
    @(negedge clk); rst_n = 1'b1;
    idle();
    chk("R8 cpu_rvalid after reset", 128'(s_crv), 0);
    chk("R8 dev_rvalid after reset", 128'(s_drv), 0);
    chk("R5 no request no ready", 128'({s_crdy, s_drdy}), 0);
  endtask

  task automatic t_single();
    bank_prio = 2'b00;
    step(1, 1, 16'h0010, 128'hA1, 0, 0, 16'h0, '0);
    chk("R5 cpu write ready", 128'(s_crdy), 1);
    chk("R6 no rvalid after write", 128'(s_crv), 0);
    step(1, 0, 16'h0010, '0, 0, 0, 16'h0, '0);
    chk("R5 cpu read ready", 128'(s_crdy), 1);
    chk("R6 cpu rvalid", 128'(s_crv), 1);
    chk("R9 cpu readback", s_crd, 128'hA1);
    idle();
    chk("R6 rvalid one cycle only", 128'(s_crv), 0);
    step(1, 1, 16'h0305, 128'hC3, 0, 0, 16'h0, '0);
    step(1, 0, 16'h0300, '0, 0, 0, 16'h0, '0);
    chk("R1 low address bits ignored", s_crd, 128'hC3);
  endtask

  task automatic t_parallel();
    bank_prio = 2'b11;
    step(1, 1, 16'h0100, 128'h11, 1, 1, 16'h8100, 128'h22);
    chk("R4 both ready on write", 128'({s_crdy, s_drdy}), 128'b11);
    step(1, 0, 16'h8100, '0, 1, 0, 16'h0100, '0);
    chk("R4 both ready on read", 128'({s_crdy, s_drdy}), 128'b11);
    chk("R1 cpu reads upper bank", s_crd, 128'h22);
    chk("R1 dev reads lower bank", s_drd, 128'h11);
  endtask

  task automatic t_conflict_hold();
    bank_prio = 2'b00;
    step(1, 1, 16'h0200, 128'hAA, 1, 1, 16'h0200, 128'hBB);
    chk("R2 lower cpu wins", 128'({s_crdy, s_drdy}), 128'b10);
    step(1, 1, 16'h0210, 128'hCC, 1, 1, 16'h0200, 128'hBB);
    chk("R3 loser stays stalled", 128'(s_drdy), 0);
    step(0, 0, 16'h0, '0, 1, 1, 16'h0200, 128'hBB);
    chk("R3 held write granted", 128'(s_drdy), 1);
    step(1, 0, 16'h0200, '0, 0, 0, 16'h0, '0);
    chk("R3 held write landed last", s_crd, 128'hBB);
  endtask

  task automatic t_dev_priority();
    bank_prio = 2'b00;
    step(1, 1, 16'h0040, 128'h40, 0, 0, 16'h0, '0);
    step(1, 1, 16'h7FF0, 128'h7F, 0, 0, 16'h0, '0);
    bank_prio = 2'b01;
    step(1, 0, 16'h7FF0, '0, 1, 0, 16'h0040, '0);
    chk("R7 distinct offsets still conflict", 128'({s_crdy, s_drdy}), 128'b01);
    chk("R6 stalled read no rvalid", 128'(s_crv), 0);
    chk("R9 dev read data", s_drd, 128'h40);
    step(1, 0, 16'h7FF0, '0, 0, 0, 16'h0, '0);
    chk("R3 held read granted", 128'(s_crdy), 1);
    chk("R3 held read data", s_crd, 128'h7F);
  endtask

  task automatic t_bank_independence();
    bank_prio = 2'b10;
    step(1, 0, 16'h8100, '0, 1, 0, 16'h8100, '0);
    chk("R2 upper dev wins", 128'({s_crdy, s_drdy}), 128'b01);
    chk("R9 dev upper data", s_drd, 128'h22);
    step(1, 0, 16'h0100, '0, 1, 0, 16'h0100, '0);
    chk("R2 lower cpu wins under 10", 128'({s_crdy, s_drdy}), 128'b10);
    bank_prio = 2'b01;
    step(1, 0, 16'h8100, '0, 1, 0, 16'hFFF0, '0);
    chk("R2 upper cpu wins under 01", 128'({s_crdy, s_drdy}), 128'b10);
    chk("R9 cpu upper data", s_crd, 128'h22);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      misses++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_single();
    t_parallel();
    t_conflict_hold();
    t_dev_priority();
    t_bank_independence();
    idle();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule